// File: doc/BRIEF.md
# Gated Selectable Clock Divider

This block conditions a single input clock for a shared output line. A static select chooses whether the clock passes straight through or is divided by two. An enable, whose polarity and undriven default are set by a two-bit mode input, gates the whole path. While gated off, the block drives both its true and complement outputs low. A line that several instances drive through a logical OR is then owned entirely by the one instance that is enabled, and it reads low on both wires when none is.

Disabling the block also clears its divide-by-two flop, and the clock cannot advance that flop while the block is off. The divided output therefore starts with a known phase every time the block is enabled. The divide select is captured only while the block is off, so changing it during operation cannot shorten a pulse. The block has no data stream: every pin is a plain control or clock level, so no valid/ready handshake or back-pressure applies.

Top module: `gdiv_clkgen`

## Requirements
- R1: With the block enabled and the captured divide select at 0, `q_o` equals `clk_in` and `qb_o` equals its inverse.
- R2: With the block enabled and the captured divide select at 1, `q_o` toggles on every rising edge of `clk_in`, `qb_o` is its inverse, and the first rising edge after enable drives `q_o` high.
- R3: While the block is disabled, `q_o` and `qb_o` are both 0, so an OR of several instances follows the single enabled one, or reads 0 on both wires when none is enabled.
- R4: Mode 2'b00 gives an active-high enable. With `en_driven` at 0, the block is enabled regardless of `en_in`.
- R5: Mode 2'b01 gives an active-high enable. With `en_driven` at 0, the block is disabled regardless of `en_in`.
- R6: Mode 2'b10 gives an active-low enable (`en_in` at 0 enables). With `en_driven` at 0, the block is enabled.
- R7: Mode 2'b11 is not a valid setting, and the block is disabled.
- R8: Disabling clears the divider, and clock edges during the off period do not advance it. After any re-enable in divide-by-two mode, the first rising edge again drives `q_o` high.
- R9: `div_sel` is captured only while the block is disabled. A change made while the block is enabled has no effect on `q_o` until the next disable.
- R10: `active_o` is 1 exactly when the decoded enable is true. It marks whether the input path is ungated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be passed or divided |
| div_sel | input | 1 | 0 = pass through, 1 = divide by two; captured while disabled |
| en_mode | input | 2 | Enable polarity and undriven default (see R4 to R7) |
| en_in | input | 1 | Enable level |
| en_driven | input | 1 | 1 when `en_in` is actively driven; 0 selects the mode's default |
| q_o | output | 1 | True clock output, low when disabled |
| qb_o | output | 1 | Complement clock output, low when disabled |
| active_o | output | 1 | Input path ungated (block enabled) |

## Verification
The bench builds three instances with the default `FIRST_PHASE` of 1, so a divided output is expected to rise on the first edge after enable. The instances sit on an OR-combined pair of lines, and each one uses a different enable mode. Switching ownership of the lines between them covers all three polarity and default settings, as well as the illegal mode. It also re-enables a divider that was left high, and it changes the divide select while the block is running. This brings the phase restart and the deferred capture of the divide select into view at the shared output.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    EM_HI_DEF_ON  = 2'b00,
    EM_HI_DEF_OFF = 2'b01,
    EM_LO_DEF_ON  = 2'b10,
    EM_INVALID    = 2'b11
  } en_mode_e;
endpackage

// File: rtl/gdiv_enable_decode.sv
module gdiv_enable_decode
  import gdiv_pkg::*;
(
  input  logic [MODE_W-1:0] en_mode,
  input  logic              en_in,
  input  logic              en_driven,
  output logic              active
);
  en_mode_e mode;

  always_comb begin
    mode = en_mode_e'(en_mode);
    unique case (mode)
      EM_HI_DEF_ON:  active = en_driven ? en_in  : 1'b1;
      EM_HI_DEF_OFF: active = en_driven ? en_in  : 1'b0;
      EM_LO_DEF_ON:  active = en_driven ? !en_in : 1'b1;
      default:       active = 1'b0;
    endcase
    // R7: the unused encoding never enables the path
    if (en_mode === 2'b11) p_bad_mode_off_r7: assert (active == 1'b0);
  end
endmodule

// File: rtl/gdiv_divider.sv
module gdiv_divider #(
  parameter bit FIRST_PHASE = 1'b1
) (
  input  logic clk_in,
  input  logic dis,
  input  logic div_sel,
  output logic mode_q,
  output logic div_q
);
  // Divide select is transparent only while the block is off.
  always_latch begin
    if (dis) mode_q = div_sel;
  end

  // Toggle flop, held at the pre-start phase by the disable.
  always_ff @(posedge clk_in or posedge dis) begin
    if (dis)         div_q <= !FIRST_PHASE;
    else if (mode_q) div_q <= !div_q;
  end

  // R2: every enabled edge in divide mode flips the flop
  p_div2_toggle_r2: assert property (@(posedge clk_in) disable iff (dis)
    mode_q |=> (div_q != $past(div_q)));

  // R8: first edge after release lands on the chosen phase
  p_first_edge_r8: assert property (@(posedge clk_in) disable iff (dis)
    (mode_q && $fell(dis)) |=> (div_q == FIRST_PHASE));

  // R9: a differing select cannot reach the captured mode while enabled
  p_mode_hold_r9: assert property (@(posedge clk_in) disable iff (dis)
    (div_sel != mode_q) |=> $stable(mode_q));
endmodule

// File: rtl/gdiv_outstage.sv
module gdiv_outstage (
  input  logic clk_in,
  input  logic div_q,
  input  logic mode_q,
  input  logic active,
  output logic q_o,
  output logic qb_o
);
  logic sel;

  always_comb begin
    sel  = mode_q ? div_q : clk_in;
    q_o  = active & sel;
    qb_o = active & !sel;
    // R3: off state pulls both wires low together
    if (active === 1'b0) p_off_low_r3: assert (q_o == 1'b0 && qb_o == 1'b0);
    // R1: on state keeps the pair complementary
    if (active === 1'b1 && (sel === 1'b0 || sel === 1'b1))
      p_complement_r1: assert (q_o != qb_o);
  end
endmodule

// File: rtl/gdiv_clkgen.sv
module gdiv_clkgen
  import gdiv_pkg::*;
#(
  parameter bit FIRST_PHASE = 1'b1
) (
  input  logic              clk_in,
  input  logic              div_sel,
  input  logic [MODE_W-1:0] en_mode,
  input  logic              en_in,
  input  logic              en_driven,
  output logic              q_o,
  output logic              qb_o,
  output logic              active_o
);
  logic active;
  logic mode_q;
  logic div_q;

  gdiv_enable_decode u_dec (
    .en_mode   (en_mode),
    .en_in     (en_in),
    .en_driven (en_driven),
    .active    (active)
  );

  gdiv_divider #(.FIRST_PHASE(FIRST_PHASE)) u_div (
    .clk_in  (clk_in),
    .dis     (!active),
    .div_sel (div_sel),
    .mode_q  (mode_q),
    .div_q   (div_q)
  );

  gdiv_outstage u_out (
    .clk_in (clk_in),
    .div_q  (div_q),
    .mode_q (mode_q),
    .active (active),
    .q_o    (q_o),
    .qb_o   (qb_o)
  );

  assign active_o = active;
endmodule

// File: tb/sim_gdiv_clkgen.sv
module sim_gdiv_clkgen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  q;
    logic  qb;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic [2:0] div_sel;
  logic [1:0] en_mode [3];
  logic [2:0] en_in;
  logic [2:0] en_driven;
  logic [2:0] q, qb, act;
  logic       bus_q, bus_qb;

  int   checks = 0;
  int   failures = 0;
  int   n_edges = 0;
  bit   finished = 0;
  exp_t sb [$];

  always #(CLK_PERIOD/2) clk = !clk;

  gdiv_clkgen u0 (.clk_in(clk), .div_sel(div_sel[0]), .en_mode(en_mode[0]),
    .en_in(en_in[0]), .en_driven(en_driven[0]), .q_o(q[0]), .qb_o(qb[0]), .active_o(act[0]));
  gdiv_clkgen u1 (.clk_in(clk), .div_sel(div_sel[1]), .en_mode(en_mode[1]),
    .en_in(en_in[1]), .en_driven(en_driven[1]), .q_o(q[1]), .qb_o(qb[1]), .active_o(act[1]));
  gdiv_clkgen u2 (.clk_in(clk), .div_sel(div_sel[2]), .en_mode(en_mode[2]),
    .en_in(en_in[2]), .en_driven(en_driven[2]), .q_o(q[2]), .qb_o(qb[2]), .active_o(act[2]));

  assign bus_q  = |q;
  assign bus_qb = |qb;

  task automatic check_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  // Monitor: compares the OR bus against the queued expectation.
  initial begin
    forever begin
      @(clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (bus_q !== e.q || bus_qb !== e.qb) begin
          failures++;
          $display("FAIL %s got=%b%b exp=%b%b t=%0t", e.tag, bus_q, bus_qb, e.q, e.qb, $time);
        end
      end
    end
  end

  // Driver: pushes the expected bus value for every half period.
  task automatic drive(input int cycles, input bit on, input bit div, input string tag);
    for (int i = 0; i < cycles; i++) begin
      logic v;
      @(posedge clk);
      if (on && div) n_edges++;
      v = on ? (div ? logic'(n_edges[0]) : 1'b1) : 1'b0;
      sb.push_back('{v, on & !v, tag});
      @(negedge clk);
      v = on ? (div ? logic'(n_edges[0]) : 1'b0) : 1'b0;
      sb.push_back('{v, on & !v, tag});
    end
    #3;
  endtask

  task automatic all_off();
    en_in     = 3'b100;
    en_driven = 3'b111;
    en_mode[2] = 2'b10;
    n_edges = 0;
  endtask

  initial begin
    div_sel    = 3'b000;
    en_mode[0] = 2'b00;
    en_mode[1] = 2'b01;
    en_mode[2] = 2'b10;
    all_off();

    // R3 reset state: nothing enabled
    drive(3, 1'b0, 1'b0, "R3");
    check_bit(|act, 1'b0, "R10");

    // R1 pass-through on u0
    en_in[0] = 1'b1;
    drive(6, 1'b1, 1'b0, "R1");
    check_bit(act[0], 1'b1, "R10");

    // R9 select change while running is ignored
    div_sel[0] = 1'b1;
    drive(4, 1'b1, 1'b0, "R9");

    // R8/R3 off, then R2 divide with new select
    all_off();
    drive(4, 1'b0, 1'b0, "R8");
    en_in[0] = 1'b1;
    drive(6, 1'b1, 1'b1, "R2");

    // R2 on u1, leave the flop high, R8 restart phase
    all_off();
    div_sel[1] = 1'b1;
    drive(2, 1'b0, 1'b0, "R3");
    en_in[1] = 1'b1;
    drive(5, 1'b1, 1'b1, "R2");
    all_off();
    drive(3, 1'b0, 1'b0, "R8");
    en_in[1] = 1'b1;
    drive(4, 1'b1, 1'b1, "R8");

    // R6 active-low u2, driven then undriven
    all_off();
    drive(1, 1'b0, 1'b0, "R3");
    en_in[2] = 1'b0;
    drive(4, 1'b1, 1'b0, "R6");
    en_in[2] = 1'b1;
    en_driven[2] = 1'b0;
    drive(4, 1'b1, 1'b0, "R6");
    check_bit(act[2], 1'b1, "R6");

    // R4 u0 undriven defaults on, divide select 1 captured
    all_off();
    drive(2, 1'b0, 1'b0, "R3");
    en_driven[0] = 1'b0;
    drive(5, 1'b1, 1'b1, "R4");
    check_bit(act[0], 1'b1, "R4");

    // R5 u1 undriven defaults off even with en_in high
    all_off();
    en_in[1] = 1'b1;
    en_driven[1] = 1'b0;
    drive(4, 1'b0, 1'b0, "R5");
    check_bit(act[1], 1'b0, "R5");

    // R7 invalid mode on u2 stays off
    all_off();
    en_mode[2] = 2'b11;
    en_in[2] = 1'b0;
    drive(4, 1'b0, 1'b0, "R7");
    check_bit(act[2], 1'b0, "R7");
    en_driven[2] = 1'b0;
    drive(2, 1'b0, 1'b0, "R7");
    check_bit(act[2], 1'b0, "R7");

    #(CLK_PERIOD);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule